// File: doc/BRIEF.md
# Parity-Preserving Reversible Full Adder

A one-bit full adder made only from reversible 4-in/4-out cells. Each cell is a bijection of its 16 input codes, and the XOR of its four inputs always equals the XOR of its four outputs. Two copies of one cell type form the adder. The first cell takes the two operands and two lines held at zero. It produces the propagate term, the generate term and a helper term. The second cell takes those three values and the carry input, and produces the sum and the carry output. Every internal net drives exactly one cell input, so no fan-out exists. Where a value would be needed twice, it would have to pass through a copying cell.

Because each cell preserves parity, the XOR of all primary inputs (the two constant zeros included) must equal the XOR of sum, carry-out and the three garbage lines. A comparator evaluates this equality and raises a fault flag when it fails. Inverting any single internal net then shows up as a flag. The block is purely combinational.

Top module: `rev_fadd`

## Requirements
- R1: `sum_o` equals `a_i ^ b_i ^ cin_i` for all eight operand combinations.
- R2: `cout_o` is 1 exactly when at least two of `a_i`, `b_i`, `cin_i` are 1.
- R3: The cell maps inputs (w,x,y,z) to outputs p=w, q=w^x, r=(w&x)^y, s=(w&~x)^z, and distinct input codes give distinct output codes (all 16 outputs differ).
- R4: For every input code of the cell, w^x^y^z equals p^q^r^s.
- R5: With no fault present, `fault_o` is 0 for every operand combination.
- R6: Inverting any one internal net (either constant line, any of the eight cell outputs) makes `fault_o` 1 for every operand combination; removing the inversion returns it to 0.
- R7: The garbage lines are `junk_o[0]` = a, `junk_o[1]` = a^b and `junk_o[2]` = ((a^b)&~cin)^(a&~b).
- R8: The eight operand combinations give eight distinct 5-bit output vectors {sum, carry, junk}, so the operands can be recovered from the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 1 | First operand bit |
| b_i | input | 1 | Second operand bit |
| cin_i | input | 1 | Carry input |
| sum_o | output | 1 | Sum bit |
| cout_o | output | 1 | Carry output |
| junk_o | output | 3 | Garbage lines needed for reversibility |
| fault_o | output | 1 | Input/output parity mismatch flag |

## Verification
A net stuck at its inverse inside either cell changes the parity of the output vector. Because the block has no storage, `fault_o` rises in the same evaluation in which the corrupted value appears on `sum_o`, `cout_o` or a garbage line. A fault on a constant line or on a first-cell output passes through the second cell. That cell keeps the error's parity, so the flag still flips even when sum and carry happen to remain correct. The bench inverts each of the ten internal nets under all eight operand patterns and expects the flag every time. When the flag is low, the sum, carry and garbage values must match the arithmetic.

// File: rtl/rfa_pkg.sv
package rfa_pkg;
    localparam int CELL_W  = 4;
    localparam int N_CONST = 2;
    localparam int N_OPER  = 3;
    localparam int N_GARB  = 3;
    localparam int N_IN    = N_OPER + N_CONST;
    localparam int N_OUT   = 2 + N_GARB;
    localparam logic CONST_LVL = 1'b0;
endpackage

// File: rtl/rev_cell4.sv
module rev_cell4 (
    input  logic w_i,
    input  logic x_i,
    input  logic y_i,
    input  logic z_i,
    output logic p_o,
    output logic q_o,
    output logic r_o,
    output logic s_o
);
    // w passes through; each other line is toggled by a function of
    // lines above it, so the map inverts line by line.
    always_comb begin
        p_o = w_i;
        q_o = w_i ^ x_i;
        r_o = (w_i & x_i) ^ y_i;
        s_o = (w_i & ~x_i) ^ z_i;
    end
endmodule

// File: rtl/rev_parity_cmp.sv
module rev_parity_cmp #(
    parameter int NI = 5,
    parameter int NO = 5
) (
    input  logic [NI-1:0] in_vec_i,
    input  logic [NO-1:0] out_vec_i,
    output logic          bad_o
);
    logic par_in_d;
    logic par_out_d;

    always_comb begin
        par_in_d  = 1'b0;
        par_out_d = 1'b0;
        for (int k = 0; k < NI; k++) par_in_d  = par_in_d ^ in_vec_i[k];
        for (int k = 0; k < NO; k++) par_out_d = par_out_d ^ out_vec_i[k];
        bad_o = par_in_d ^ par_out_d;
    end
endmodule

// File: rtl/rev_fadd.sv
module rev_fadd
    import rfa_pkg::*;
(
    input  logic              a_i,
    input  logic              b_i,
    input  logic              cin_i,
    output logic              sum_o,
    output logic              cout_o,
    output logic [N_GARB-1:0] junk_o,
    output logic              fault_o
);
    // constant lines of the first cell
    logic k_c1;
    logic k_d1;
    // first cell outputs
    logic n1_p, n1_q, n1_r, n1_s;
    // second cell outputs
    logic n2_p, n2_q, n2_r, n2_s;

    assign k_c1 = CONST_LVL;
    assign k_d1 = CONST_LVL;

    // cell 1: operands and two zero lines -> a, propagate, generate, a&~b
    rev_cell4 u_c1 (
        .w_i(a_i),  .x_i(b_i),  .y_i(k_c1), .z_i(k_d1),
        .p_o(n1_p), .q_o(n1_q), .r_o(n1_r), .s_o(n1_s)
    );

    // cell 2: propagate, carry-in, generate, helper -> sum in q, carry in r
    rev_cell4 u_c2 (
        .w_i(n1_q), .x_i(cin_i), .y_i(n1_r), .z_i(n1_s),
        .p_o(n2_p), .q_o(n2_q),  .r_o(n2_r), .s_o(n2_s)
    );

    assign sum_o  = n2_q;
    assign cout_o = n2_r;
    assign junk_o = {n2_s, n2_p, n1_p};

    // the input side uses the port values and the literal constants,
    // not the constant nets, so a corrupted constant line is still caught
    rev_parity_cmp #(.NI(N_IN), .NO(N_OUT)) u_par (
        .in_vec_i ({a_i, b_i, cin_i, {N_CONST{CONST_LVL}}}),
        .out_vec_i({sum_o, cout_o, junk_o}),
        .bad_o    (fault_o)
    );
endmodule

// File: rtl/rev_fadd_chk.sv
module rev_fadd_chk (
    input logic       a_i,
    input logic       b_i,
    input logic       cin_i,
    input logic       sum_o,
    input logic       cout_o,
    input logic [2:0] junk_o,
    input logic       fault_o,
    input logic [3:0] c1_in,
    input logic [3:0] c1_out,
    input logic [3:0] c2_in,
    input logic [3:0] c2_out
);
    always_comb begin
        if (!$isunknown({a_i, b_i, cin_i, fault_o}) && !fault_o) begin
            p_sum_r1: assert (sum_o == (a_i ^ b_i ^ cin_i));
            p_carry_r2: assert (cout_o == ((a_i & b_i) | (a_i & cin_i) | (b_i & cin_i)));
            p_cell1_par_r4: assert ((^c1_in) == (^c1_out));
            p_cell2_par_r4: assert ((^c2_in) == (^c2_out));
            p_garb_r7: assert (junk_o[0] == a_i && junk_o[1] == (a_i ^ b_i));
        end
    end
endmodule

bind rev_fadd rev_fadd_chk u_chk (
    .a_i    (a_i),
    .b_i    (b_i),
    .cin_i  (cin_i),
    .sum_o  (sum_o),
    .cout_o (cout_o),
    .junk_o (junk_o),
    .fault_o(fault_o),
    .c1_in  ({a_i, b_i, k_c1, k_d1}),
    .c1_out ({n1_p, n1_q, n1_r, n1_s}),
    .c2_in  ({n1_q, cin_i, n1_r, n1_s}),
    .c2_out ({n2_p, n2_q, n2_r, n2_s})
);

// File: tb/sim_rev_fadd.sv
`timescale 1ns/100ps
module sim_rev_fadd;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic a, b, cin;
    logic sum_w, cout_w, fault_w;
    logic [2:0] junk_w;

    rev_fadd u0 (
        .a_i(a), .b_i(b), .cin_i(cin),
        .sum_o(sum_w), .cout_o(cout_w), .junk_o(junk_w), .fault_o(fault_w)
    );

    logic cw, cx, cy, cz, cp, cq, cr, cs;
    rev_cell4 u_cell (
        .w_i(cw), .x_i(cx), .y_i(cy), .z_i(cz),
        .p_o(cp), .q_o(cq), .r_o(cr), .s_o(cs)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // behavioural value an internal net takes for operands (av,bv,cv)
    function automatic logic net_val(input int idx, input int av, input int bv, input int cv);
        int t, lo;
        t  = av + bv + cv;
        lo = (av == 1 && bv == 0) ? 1 : 0;
        case (idx)
            0, 1: return 1'b0;
            2: return 1'(av);
            3: return 1'((av + bv) % 2);
            4: return 1'(av * bv);
            5: return 1'(lo);
            6: return 1'((av + bv) % 2);
            7: return 1'(t % 2);
            8: return 1'(t / 2);
            default: return 1'(((((av + bv) % 2 == 1) && cv == 0) ? 1 : 0) ^ lo);
        endcase
    endfunction

    task automatic inject(input int idx, input logic v);
        case (idx)
            0: force u0.k_c1 = v;
            1: force u0.k_d1 = v;
            2: force u0.n1_p = v;
            3: force u0.n1_q = v;
            4: force u0.n1_r = v;
            5: force u0.n1_s = v;
            6: force u0.n2_p = v;
            7: force u0.n2_q = v;
            8: force u0.n2_r = v;
            default: force u0.n2_s = v;
        endcase
    endtask

    task automatic clear(input int idx);
        case (idx)
            0: release u0.k_c1;
            1: release u0.k_d1;
            2: release u0.n1_p;
            3: release u0.n1_q;
            4: release u0.n1_r;
            5: release u0.n1_s;
            6: release u0.n2_p;
            7: release u0.n2_q;
            8: release u0.n2_r;
            default: release u0.n2_s;
        endcase
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int seen[$];
        bit used[16];
        int distinct;
        a = 0; b = 0; cin = 0;
        cw = 0; cx = 0; cy = 0; cz = 0;
        @(negedge clk);
        // reset-like idle state: all-zero operands
        chk("R1 idle sum", int'(sum_w), 0);
        chk("R5 idle flag", int'(fault_w), 0);

        // R3/R4: exhaustive cell enumeration
        for (int v = 0; v < 16; v++) begin
            int w, x, y, z, ep, eq, er, es, code;
            w = (v >> 3) & 1; x = (v >> 2) & 1; y = (v >> 1) & 1; z = v & 1;
            {cw, cx, cy, cz} = 4'(v);
            @(negedge clk);
            ep = w;
            eq = (w + x) % 2;
            er = ((w * x) + y) % 2;
            es = ((w == 1 && x == 0 ? 1 : 0) + z) % 2;
            code = {cp, cq, cr, cs};
            chk("R3 cell map", code, ep * 8 + eq * 4 + er * 2 + es);
            chk("R4 cell parity", (cp ^ cq ^ cr ^ cs), (w + x + y + z) % 2);
            used[code] = 1'b1;
        end
        distinct = 0;
        for (int k = 0; k < 16; k++) if (used[k]) distinct++;
        chk("R3 bijective", distinct, 16);

        // R1, R2, R5, R7, R8: fault-free operands
        for (int v = 0; v < 8; v++) begin
            int av, bv, cv, t, vec;
            av = (v >> 2) & 1; bv = (v >> 1) & 1; cv = v & 1;
            a = 1'(av); b = 1'(bv); cin = 1'(cv);
            @(negedge clk);
            t = av + bv + cv;
            chk("R1 sum", int'(sum_w), t % 2);
            chk("R2 carry", int'(cout_w), t / 2);
            chk("R5 no fault", int'(fault_w), 0);
            chk("R7 junk0", int'(junk_w[0]), av);
            chk("R7 junk1", int'(junk_w[1]), (av + bv) % 2);
            chk("R7 junk2", int'(junk_w[2]), int'(net_val(9, av, bv, cv)));
            vec = {sum_w, cout_w, junk_w};
            foreach (seen[k]) chk("R8 distinct", int'(seen[k] == vec), 0);
            seen.push_back(vec);
        end

        // R6: single-net inversion
        for (int n = 0; n < 10; n++) begin
            for (int v = 0; v < 8; v++) begin
                int av, bv, cv;
                av = (v >> 2) & 1; bv = (v >> 1) & 1; cv = v & 1;
                a = 1'(av); b = 1'(bv); cin = 1'(cv);
                inject(n, ~net_val(n, av, bv, cv));
                @(negedge clk);
                chk($sformatf("R6 net %0d flagged", n), int'(fault_w), 1);
                clear(n);
                @(negedge clk);
                chk($sformatf("R6 net %0d released", n), int'(fault_w), 0);
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule